// File: doc/BRIEF.md
# Message object control flag register with set/clear pairs

This block holds the eight control and status flags of one message object in a CAN controller. Each flag is written and read as a two-bit pair: one bit carries the flag value and the other carries its complement. A software byte write can therefore set some flags, clear others and leave the rest alone, and it needs no read-modify-write sequence. The protocol engine updates the same flags through per-flag set and clear strobes and through three event strobes: message stored, object loaded for transmission, and transmission done. The block also drives the object's interrupt request and its interrupt identifier.

The flags are packed into two bytes. Byte 0 holds valid, transmit interrupt enable, receive interrupt enable and interrupt pending. Byte 1 holds new data, message lost (which acts as CPU update on a transmit object), transmit request and remote pending. On a receive object, a message that lands while new data is still set marks the message as lost. A transmit object is offered for sending only when it is valid, has its request set and is not being updated by software.

Top module: `msg_ctrl_pairs`

## Requirements
- R1: After reset all eight flags are clear, so cpu_rdata_o reads 16'h5555. irq_o and tx_ready_o are 0, and irq_id_o is 0.
- R2: Flag k uses bits [2k+1:2k] of the 16-bit word. Byte 0 (bits 7:0, enabled by cpu_we_i[0]) holds k=0 valid, k=1 transmit interrupt enable, k=2 receive interrupt enable and k=3 interrupt pending. Byte 1 (bits 15:8, enabled by cpu_we_i[1]) holds k=4 new data, k=5 lost/CPU update, k=6 transmit request and k=7 remote pending. On an enabled byte, pair code 2'b10 sets the flag at the next clock edge and 2'b01 clears it. Codes 2'b11 and 2'b00 leave it unchanged. Pairs in a disabled byte are unchanged.
- R3: cpu_rdata_o shows each flag as 2'b10 when it is set and as 2'b01 when it is clear, in the positions given in R2.
- R4: When ctl_set_i[k] or ctl_clr_i[k] is high in the same cycle as a CPU write to flag k, the strobe decides flag k, and a set strobe wins over a clear strobe. In the same cycle the CPU write still updates the other flags.
- R5: rx_store_i sets new data. On a receive object (dir_tx_i=0), rx_store_i also sets lost if new data was already set before the edge.
- R6: rx_store_i sets interrupt pending only on a receive object whose receive interrupt enable is set. On a transmit object (dir_tx_i=1) it never sets pending or lost.
- R7: tx_done_i clears transmit request. It sets interrupt pending only on a transmit object whose transmit interrupt enable is set.
- R8: tx_load_i clears new data, unless rx_store_i or ctl_set_i[4] is asserted in the same cycle.
- R9: tx_ready_o is high exactly when dir_tx_i is 1 and valid is set, transmit request is set and lost/CPU update is clear.
- R10: irq_o equals the interrupt pending flag. irq_id_o equals OBJ_NUM+1 while pending is set and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 2 | Byte write enables for the CPU write |
| cpu_wdata_i | input | 16 | CPU write data, one pair per flag |
| cpu_rdata_o | output | 16 | Flags in pair encoding |
| dir_tx_i | input | 1 | Object direction: 1 transmit, 0 receive |
| ctl_set_i | input | 8 | Controller per-flag set strobes |
| ctl_clr_i | input | 8 | Controller per-flag clear strobes |
| rx_store_i | input | 1 | Controller stored a message into the object |
| tx_load_i | input | 1 | Controller loaded the object for sending |
| tx_done_i | input | 1 | Controller finished a successful send |
| tx_ready_o | output | 1 | Object is eligible for transmission |
| irq_o | output | 1 | Object interrupt request |
| irq_id_o | output | 8 | Interrupt identifier of this object, 0 when idle |

## Verification
Both bytes are swept exhaustively. Every starting state of the four flags in a byte is combined with all 256 write values, while the other byte holds a complementary pattern. This separates the four pair codes from one another and shows that a write never reaches the disabled byte. A second sweep crosses every flag, every pair code and every strobe kind against both starting values. The CPU write flips all other flags in the same cycle, which exposes any priority error or any leak of one flag's update into another. The event strobes are tried across direction, interrupt enable and prior new-data state. The transmit-ready and interrupt outputs are then checked against all combinations of their inputs.

// File: rtl/ctlpair_pkg.sv
package ctlpair_pkg;
  localparam int NUM_FLAGS      = 8;
  localparam int PAIR_W         = 2;
  localparam int BYTE_W         = 8;
  localparam int FLAGS_PER_BYTE = BYTE_W / PAIR_W;
  localparam int NUM_BYTES      = NUM_FLAGS / FLAGS_PER_BYTE;
  localparam int WORD_W         = NUM_FLAGS * PAIR_W;

  localparam int F_VALID = 0;
  localparam int F_TXIE  = 1;
  localparam int F_RXIE  = 2;
  localparam int F_PEND  = 3;
  localparam int F_NEW   = 4;
  localparam int F_LOST  = 5;
  localparam int F_TXREQ = 6;
  localparam int F_RMT   = 7;

  localparam logic [PAIR_W-1:0] PAIR_SET = 2'b10;
  localparam logic [PAIR_W-1:0] PAIR_CLR = 2'b01;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  function automatic logic [PAIR_W-1:0] pair_of(input logic f);
    return f ? PAIR_SET : PAIR_CLR;
  endfunction
endpackage

// File: rtl/ctlpair_cell.sv
module ctlpair_cell
  import ctlpair_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [PAIR_W-1:0] cpu_code_i,
  input  logic              hw_set_i,
  input  logic              hw_clr_i,
  output logic              q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                q_q <= 1'b0;
    else if (hw_set_i)                          q_q <= 1'b1;
    else if (hw_clr_i)                          q_q <= 1'b0;
    else if (cpu_wr_i && cpu_code_i == PAIR_SET) q_q <= 1'b1;
    else if (cpu_wr_i && cpu_code_i == PAIR_CLR) q_q <= 1'b0;
  end

  assign q_o = q_q;

  p_hw_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i |=> q_o);
  p_hw_clr_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_i && !hw_set_i) |=> !q_o);
  p_hold_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_set_i && !hw_clr_i && (!cpu_wr_i || cpu_code_i[0] == cpu_code_i[1])) |=> $stable(q_o));
endmodule

// File: rtl/ctlpair_events.sv
module ctlpair_events
  import ctlpair_pkg::*;
(
  input  flag_vec_t flags_i,
  input  logic      dir_tx_i,
  input  flag_vec_t ctl_set_i,
  input  flag_vec_t ctl_clr_i,
  input  logic      rx_store_i,
  input  logic      tx_load_i,
  input  logic      tx_done_i,
  output flag_vec_t set_o,
  output flag_vec_t clr_o
);
  flag_vec_t ev_set, ev_clr;
  logic      rx_obj;

  assign rx_obj = !dir_tx_i;

  always_comb begin
    ev_set = '0;
    ev_clr = '0;
    if (rx_store_i) begin
      ev_set[F_NEW]  = 1'b1;
      ev_set[F_LOST] = rx_obj && flags_i[F_NEW];
      ev_set[F_PEND] = rx_obj && flags_i[F_RXIE];
    end
    if (tx_done_i) begin
      ev_clr[F_TXREQ] = 1'b1;
      if (dir_tx_i && flags_i[F_TXIE]) ev_set[F_PEND] = 1'b1;
    end
    if (tx_load_i) ev_clr[F_NEW] = 1'b1;
  end

  assign set_o = ctl_set_i | ev_set;
  assign clr_o = ctl_clr_i | ev_clr;
endmodule

// File: rtl/msg_ctrl_pairs.sv
module msg_ctrl_pairs
  import ctlpair_pkg::*;
#(
  parameter int OBJ_NUM = 1,
  parameter int ID_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BYTES-1:0] cpu_we_i,
  input  logic [WORD_W-1:0]    cpu_wdata_i,
  output logic [WORD_W-1:0]    cpu_rdata_o,
  input  logic                 dir_tx_i,
  input  logic [NUM_FLAGS-1:0] ctl_set_i,
  input  logic [NUM_FLAGS-1:0] ctl_clr_i,
  input  logic                 rx_store_i,
  input  logic                 tx_load_i,
  input  logic                 tx_done_i,
  output logic                 tx_ready_o,
  output logic                 irq_o,
  output logic [ID_W-1:0]      irq_id_o
);
  localparam logic [ID_W-1:0] IRQ_ID = ID_W'(OBJ_NUM + 1);

  flag_vec_t flags_q, hw_set, hw_clr;

  ctlpair_events u_events (
    .flags_i   (flags_q),
    .dir_tx_i  (dir_tx_i),
    .ctl_set_i (ctl_set_i),
    .ctl_clr_i (ctl_clr_i),
    .rx_store_i(rx_store_i),
    .tx_load_i (tx_load_i),
    .tx_done_i (tx_done_i),
    .set_o     (hw_set),
    .clr_o     (hw_clr)
  );

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    ctlpair_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cpu_wr_i  (cpu_we_i[k/FLAGS_PER_BYTE]),
      .cpu_code_i(cpu_wdata_i[k*PAIR_W +: PAIR_W]),
      .hw_set_i  (hw_set[k]),
      .hw_clr_i  (hw_clr[k]),
      .q_o       (flags_q[k])
    );
    assign cpu_rdata_o[k*PAIR_W +: PAIR_W] = pair_of(flags_q[k]);
  end

  // CPU update flag blocks offering while software rewrites the data
  assign tx_ready_o = dir_tx_i && flags_q[F_VALID] && flags_q[F_TXREQ] && !flags_q[F_LOST];
  assign irq_o      = flags_q[F_PEND];
  assign irq_id_o   = flags_q[F_PEND] ? IRQ_ID : '0;

  p_rx_lost_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_store_i && !dir_tx_i && flags_q[F_NEW]) |=> flags_q[F_LOST]);
  p_rx_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_store_i && !dir_tx_i && flags_q[F_RXIE]) |=> irq_o);
  p_txdone_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !ctl_set_i[F_TXREQ]) |=> !tx_ready_o);
  p_txload_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_i && !rx_store_i && !ctl_set_i[F_NEW]) |=> (cpu_rdata_o[F_NEW*PAIR_W +: PAIR_W] == PAIR_CLR));
  p_irq_id_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_id_o != '0) |-> irq_o);
endmodule

// File: tb/msg_ctrl_pairs_tb_top.sv
`timescale 1ns/1ps
module msg_ctrl_pairs_tb_top;
  localparam int OBJ = 5;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  cpu_we_i = '0;
  logic [15:0] cpu_wdata_i = '0, cpu_rdata_o;
  logic        dir_tx_i = 1'b0;
  logic [7:0]  ctl_set_i = '0, ctl_clr_i = '0;
  logic        rx_store_i = 1'b0, tx_load_i = 1'b0, tx_done_i = 1'b0;
  logic        tx_ready_o, irq_o;
  logic [7:0]  irq_id_o;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  msg_ctrl_pairs #(.OBJ_NUM(OBJ), .ID_W(8)) dut_i (.*);

  function automatic logic [15:0] enc(input logic [7:0] f);
    logic [15:0] r;
    for (int k = 0; k < 8; k++) r[2*k +: 2] = f[k] ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic logic [7:0] cpu_model(input logic [7:0] f, input logic [1:0] we, input logic [15:0] d);
    logic [7:0] r = f;
    for (int k = 0; k < 8; k++)
      if (we[k/4]) begin
        if (d[2*k +: 2] == 2'b10) r[k] = 1'b1;
        else if (d[2*k +: 2] == 2'b01) r[k] = 1'b0;
      end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle; outputs sampled 1 ns after the edge that registers it
  task automatic cyc(input logic [1:0] we, input logic [15:0] d, input logic [7:0] s = 0,
                     input logic [7:0] c = 0, input logic rx = 0, input logic ld = 0, input logic dn = 0);
    cpu_we_i = we; cpu_wdata_i = d; ctl_set_i = s; ctl_clr_i = c;
    rx_store_i = rx; tx_load_i = ld; tx_done_i = dn;
    @(posedge clk_i); #1;
    cpu_we_i = '0; ctl_set_i = '0; ctl_clr_i = '0;
    rx_store_i = 0; tx_load_i = 0; tx_done_i = 0;
  endtask

  task automatic load(input logic [7:0] f);
    cyc(2'b11, enc(f));
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] e;
    #1;
    chk("R1 reset rdata", cpu_rdata_o, 16'h5555);
    chk("R1 reset irq", {irq_o, tx_ready_o, irq_id_o}, 0);
    #10 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after release", cpu_rdata_o, 16'h5555);

    // R2 R3: exhaustive per byte
    for (int b = 0; b < 2; b++)
      for (int st = 0; st < 16; st++)
        for (int w = 0; w < 256; w++) begin
          logic [7:0] f0;
          logic [15:0] wd;
          f0 = (b == 0) ? {~st[3:0], st[3:0]} : {st[3:0], ~st[3:0]};
          load(f0);
          wd = (b == 0) ? {8'h00, w[7:0]} : {w[7:0], 8'h00};
          cyc(2'b01 << b, wd);
          chk("R2 R3 byte write", cpu_rdata_o, enc(cpu_model(f0, 2'b01 << b, wd)));
        end

    // R4: controller strobe against CPU write
    for (int k = 0; k < 8; k++)
      for (int code = 0; code < 4; code++)
        for (int op = 0; op < 3; op++)
          for (int st = 0; st < 2; st++) begin
            logic [15:0] wd;
            logic [7:0] s, c;
            dir_tx_i = 1'b0;
            load(st ? 8'hFF : 8'h00);
            wd = enc(st ? 8'h00 : 8'hFF);
            wd[2*k +: 2] = code[1:0];
            s = (op != 1) ? (8'h1 << k) : 8'h0;
            c = (op != 0) ? (8'h1 << k) : 8'h0;
            cyc(2'b11, wd, s, c);
            e = st ? 8'h00 : 8'hFF;
            e[k] = (op != 1);
            chk("R4 strobe priority", cpu_rdata_o, enc(e));
          end

    // R5 R6: message stored
    for (int d = 0; d < 2; d++)
      for (int ie = 0; ie < 2; ie++)
        for (int nw = 0; nw < 2; nw++) begin
          dir_tx_i = d[0];
          e = 8'h01; e[2] = ie[0]; e[4] = nw[0];
          load(e);
          cyc(2'b00, 16'h0, 8'h0, 8'h0, 1'b1);
          e[4] = 1'b1;
          e[5] = (d == 0) && nw[0];
          e[3] = (d == 0) && ie[0];
          chk("R5 R6 rx store", cpu_rdata_o, enc(e));
          chk("R6 rx irq", irq_o, e[3]);
        end

    // R7: transmission done
    for (int d = 0; d < 2; d++)
      for (int ie = 0; ie < 2; ie++) begin
        dir_tx_i = d[0];
        e = 8'h41; e[1] = ie[0];
        load(e);
        chk("R9 ready before done", tx_ready_o, d[0]);
        cyc(2'b00, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b1);
        e[6] = 1'b0;
        e[3] = d[0] && ie[0];
        chk("R7 tx done", cpu_rdata_o, enc(e));
        chk("R7 ready dropped", tx_ready_o, 1'b0);
      end

    // R8: load into transmit buffer
    dir_tx_i = 1'b1;
    load(8'h10);
    cyc(2'b00, 16'h0, 8'h0, 8'h0, 1'b0, 1'b1);
    chk("R8 load clears new", cpu_rdata_o, enc(8'h00));
    load(8'h10);
    cyc(2'b00, 16'h0, 8'h0, 8'h0, 1'b1, 1'b1);
    chk("R8 store beats load", cpu_rdata_o, enc(8'h10));

    // R9: ready combinations
    for (int m = 0; m < 16; m++) begin
      dir_tx_i = m[3];
      e = 8'h00; e[0] = m[0]; e[6] = m[1]; e[5] = m[2];
      load(e);
      chk("R9 tx ready", tx_ready_o, m[3] && m[0] && m[1] && !m[2]);
    end

    // R10: interrupt and identifier
    load(8'h08);
    chk("R10 irq set", {irq_o, irq_id_o}, {1'b1, 8'(OBJ + 1)});
    cyc(2'b01, 16'h0040);
    chk("R10 irq cleared", {irq_o, irq_id_o}, 9'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule